// File: doc/BRIEF.md
# Prioritized Interrupt Controller with Programmable Sensing

The controller collects a parameterized set of interrupt inputs and presents the most urgent one to a single processor. For each input, software picks one of four sensing styles and an 8-bit urgency value. The sensing style can be a level of either polarity or an edge of either direction. Both settings sit in packed 32-bit configuration words. Inputs numbered below a boundary parameter keep their words in a private region of the map. The remaining inputs use a shared region, where they are indexed relative to the boundary.

Software switches one input on or off by writing that input's number to a dedicated register. When the processor interrupt line rises, software reads a ready register. The read returns the number of the winning input and, in the same cycle, marks that input as being serviced. When the handler finishes, software writes the number to an acknowledge register. After the acknowledge, the input may be presented again.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset every input is disabled and not in service, and every sensing code and urgency value is 0. Every configuration word reads 0, `cpu_irq_o` is low, and a ready read returns the idle word 0x0000_0000.
- R2: Sensing code 0 treats an input as requesting while it is high. Code 1 treats it as requesting while it is low. In both level codes the request follows the input with no latching.
- R3: Sensing code 2 latches a request on a 0-to-1 change of the input, and code 3 latches it on a 1-to-0 change. The latch is sampled on the clock. It survives the input returning to its idle value and is cleared only by an acknowledge of that input, or by moving the input to a level code. When an edge arrives in the same cycle as an acknowledge, the edge is kept.
- R4: Sensing codes take 2 bits per input, 16 inputs per word. Input i below the boundary uses the word at 0x014 + 4*floor(2i/32), bits starting at 2i mod 32. For an input at or above the boundary, let j = i - boundary. It uses the word at 0x100 + 4*floor(2j/32), bits starting at 2j mod 32.
- R5: Urgency values take 8 bits per input, 4 inputs per word. Input i below the boundary uses the word at 0x020 + 4*floor(8i/32), bits starting at 8i mod 32. An input at or above the boundary uses 0x200 + 4*floor(8j/32), bits starting at 8j mod 32, with j = i - boundary.
- R6: Writing an input number to 0x0A0 enables that input, and writing it to 0x0A4 disables it. A number not below the input count changes no enable, and a disabled input is never presented.
- R7: Of the inputs that are requesting, enabled and not in service, the one with the largest urgency value wins. Among equal values, the lowest input number wins.
- R8: A read of 0x06C returns bit 31 set with the winner's number in the low bits, or the idle word 0x0000_0000 when no input qualifies.
- R9: A ready read that returns an input puts that input in service. It is then not presented again until acknowledged, while other inputs may still win.
- R10: Writing an input number to 0x0B4 takes that input out of service. A level input that is still active is presented again on the next cycle. A number not below the input count is ignored.
- R11: `cpu_irq_o` is high exactly when a ready read would return a valid number.
- R12: A register write takes effect from the clock edge that samples it. Read data appears on `bus_rdata_o` after the clock edge that samples the read, and is held until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_src_i | input | NUM_SRC | Interrupt inputs, one bit per input number |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe |
| bus_addr_i | input | ADDR_W | Register byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Registered read data |
| cpu_irq_o | output | 1 | Interrupt request to the processor |

## Verification
The arbitration is first tried with hand-built patterns. Two inputs with equal urgency separate the tie rule from the magnitude rule. Raising one of them shows that the new value takes effect immediately. Alternating reads of inputs that are still active show that service masking lets the other input through. Each edge code gets a single pulse that has ended before the read, which shows that edges are latched and levels are not. A long random phase then toggles inputs, rewrites configuration words, and mixes enables, reads and acknowledges, including out-of-range numbers. A bench model follows the stated rules, and every read value and the interrupt line in every cycle are compared against it.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

   localparam int PRIO_W = 8;
   localparam int SNS_W  = 2;

   typedef enum logic [SNS_W-1:0] {
      SNS_LVL_HI = 2'd0,
      SNS_LVL_LO = 2'd1,
      SNS_RISE   = 2'd2,
      SNS_FALL   = 2'd3
   } sense_e;

   localparam int OFS_LOC_SENSE = 'h014;
   localparam int OFS_LOC_PRIO  = 'h020;
   localparam int OFS_READY     = 'h06C;
   localparam int OFS_SET_EN    = 'h0A0;
   localparam int OFS_CLR_EN    = 'h0A4;
   localparam int OFS_ACK       = 'h0B4;
   localparam int OFS_SHR_SENSE = 'h100;
   localparam int OFS_SHR_PRIO  = 'h200;

   localparam logic [31:0] IDLE_WORD = 32'h0000_0000;

   // byte address of the packed word that holds field idx of width fw
   function automatic int fld_addr(int idx, int nloc, int loc_base, int shr_base, int fw);
      int j;
      j = (idx < nloc) ? idx : idx - nloc;
      return ((idx < nloc) ? loc_base : shr_base) + ((j * fw) / 32) * 4;
   endfunction

   // lowest bit of field idx inside its packed word
   function automatic int fld_lsb(int idx, int nloc, int fw);
      int j;
      j = (idx < nloc) ? idx : idx - nloc;
      return (j * fw) % 32;
   endfunction

endpackage

// File: rtl/irqc_regs.sv
module irqc_regs
   import irqc_pkg::*;
#(
   parameter int NUM_SRC   = 32,
   parameter int NUM_LOCAL = 16,
   parameter int ADDR_W    = 12
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              wr_i,
   input  logic [ADDR_W-1:0]                 addr_i,
   input  logic [31:0]                       wdata_i,
   output logic [NUM_SRC-1:0][SNS_W-1:0]     sense_o,
   output logic [NUM_SRC-1:0][PRIO_W-1:0]    prio_o,
   output logic [NUM_SRC-1:0]                en_o,
   output logic [31:0]                       cfg_rdata_o
);

   localparam logic [ADDR_W-1:0] A_SET = ADDR_W'(OFS_SET_EN);
   localparam logic [ADDR_W-1:0] A_CLR = ADDR_W'(OFS_CLR_EN);

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
      localparam int SA = fld_addr(i, NUM_LOCAL, OFS_LOC_SENSE, OFS_SHR_SENSE, SNS_W);
      localparam int SL = fld_lsb(i, NUM_LOCAL, SNS_W);
      localparam int PA = fld_addr(i, NUM_LOCAL, OFS_LOC_PRIO, OFS_SHR_PRIO, PRIO_W);
      localparam int PL = fld_lsb(i, NUM_LOCAL, PRIO_W);

      logic [SNS_W-1:0]  sense_r;
      logic [PRIO_W-1:0] prio_r;
      logic              en_r;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            sense_r <= SNS_LVL_HI;
            prio_r  <= '0;
            en_r    <= 1'b0;
         end else if (wr_i) begin
            if (addr_i == ADDR_W'(SA)) sense_r <= wdata_i[SL +: SNS_W];
            if (addr_i == ADDR_W'(PA)) prio_r  <= wdata_i[PL +: PRIO_W];
            if (addr_i == A_SET && wdata_i == 32'(i)) en_r <= 1'b1;
            if (addr_i == A_CLR && wdata_i == 32'(i)) en_r <= 1'b0;
         end
      end

      assign sense_o[i] = sense_r;
      assign prio_o[i]  = prio_r;
      assign en_o[i]    = en_r;

      a_r6_set_enables: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_i && addr_i == A_SET && wdata_i == 32'(i)) |=> en_o[i]);
      a_r6_clr_disables: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_i && addr_i == A_CLR && wdata_i == 32'(i)) |=> !en_o[i]);
   end

   always_comb begin
      cfg_rdata_o = '0;
      for (int i = 0; i < NUM_SRC; i++) begin
         if (addr_i == ADDR_W'(fld_addr(i, NUM_LOCAL, OFS_LOC_SENSE, OFS_SHR_SENSE, SNS_W)))
            cfg_rdata_o = cfg_rdata_o | (32'(sense_o[i]) << fld_lsb(i, NUM_LOCAL, SNS_W));
         if (addr_i == ADDR_W'(fld_addr(i, NUM_LOCAL, OFS_LOC_PRIO, OFS_SHR_PRIO, PRIO_W)))
            cfg_rdata_o = cfg_rdata_o | (32'(prio_o[i]) << fld_lsb(i, NUM_LOCAL, PRIO_W));
      end
   end

   // R6: an out-of-range number leaves every enable untouched
   a_r6_range_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && (addr_i == A_SET || addr_i == A_CLR) && wdata_i >= 32'(NUM_SRC)) |=> $stable(en_o));

endmodule

// File: rtl/irqc_src.sv
module irqc_src
   import irqc_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             irq_i,
   input  logic [SNS_W-1:0] mode_i,
   input  logic             en_i,
   input  logic             take_i,
   input  logic             ack_i,
   output logic             req_o
);

   logic prev_q, latch_q, insvc_q;
   logic is_edge, lvl_act, edge_now, pend;

   always_comb begin
      is_edge  = mode_i[1];
      lvl_act  = irq_i ^ (mode_i == SNS_LVL_LO);
      unique case (mode_i)
         SNS_RISE: edge_now = irq_i & ~prev_q;
         SNS_FALL: edge_now = ~irq_i & prev_q;
         default:  edge_now = 1'b0;
      endcase
      pend  = is_edge ? latch_q : lvl_act;
      req_o = pend & en_i & ~insvc_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q  <= 1'b0;
         latch_q <= 1'b0;
         insvc_q <= 1'b0;
      end else begin
         prev_q <= irq_i;
         if (!is_edge)      latch_q <= 1'b0;
         else if (edge_now) latch_q <= 1'b1;
         else if (ack_i)    latch_q <= 1'b0;
         if (take_i)        insvc_q <= 1'b1;
         else if (ack_i)    insvc_q <= 1'b0;
      end
   end

   a_r3_latch_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (is_edge && latch_q && !ack_i) |=> latch_q);
   a_r9_service_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (insvc_q && !ack_i) |=> insvc_q);
   a_r10_ack_releases: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_i && !take_i) |=> !insvc_q);
   a_r9_taken_masked: assert property (@(posedge clk) disable iff (!rst_n)
      take_i |=> !req_o);

endmodule

// File: rtl/irqc_arb.sv
module irqc_arb
   import irqc_pkg::*;
#(
   parameter int NUM_SRC = 32,
   parameter int ID_W    = $clog2(NUM_SRC)
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic [NUM_SRC-1:0]             req_i,
   input  logic [NUM_SRC-1:0][PRIO_W-1:0] prio_i,
   output logic                           valid_o,
   output logic [ID_W-1:0]                id_o
);

   logic [PRIO_W-1:0] best;

   // strict compare: an equal value never displaces a lower number
   always_comb begin
      valid_o = 1'b0;
      id_o    = '0;
      best    = '0;
      for (int i = 0; i < NUM_SRC; i++) begin
         if (req_i[i] && (!valid_o || prio_i[i] > best)) begin
            valid_o = 1'b1;
            id_o    = ID_W'(i);
            best    = prio_i[i];
         end
      end
   end

   a_r7_winner_requests: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |-> req_i[id_o]);

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_chk
      a_r7_none_higher: assert property (@(posedge clk) disable iff (!rst_n)
         req_i[i] |-> (valid_o && prio_i[id_o] >= prio_i[i]));
      a_r7_tie_lowest: assert property (@(posedge clk) disable iff (!rst_n)
         (req_i[i] && prio_i[i] == prio_i[id_o]) |-> (32'(id_o) <= i));
   end

endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
   import irqc_pkg::*;
#(
   parameter int NUM_SRC   = 32,
   parameter int NUM_LOCAL = 16,
   parameter int ADDR_W    = 12
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] irq_src_i,
   input  logic               bus_wr_i,
   input  logic               bus_rd_i,
   input  logic [ADDR_W-1:0]  bus_addr_i,
   input  logic [31:0]        bus_wdata_i,
   output logic [31:0]        bus_rdata_o,
   output logic               cpu_irq_o
);

   localparam int ID_W = $clog2(NUM_SRC);
   localparam logic [ADDR_W-1:0] A_READY = ADDR_W'(OFS_READY);
   localparam logic [ADDR_W-1:0] A_ACK   = ADDR_W'(OFS_ACK);

   if (NUM_SRC < 2 || NUM_LOCAL < 1 || NUM_LOCAL > NUM_SRC || NUM_LOCAL > 48 ||
       NUM_SRC - NUM_LOCAL > 256 || ADDR_W < 12) begin : g_bad_cfg
      $error("irq_prio_ctrl: unsupported parameter set");
   end

   logic [NUM_SRC-1:0][SNS_W-1:0]  sense;
   logic [NUM_SRC-1:0][PRIO_W-1:0] prio;
   logic [NUM_SRC-1:0]             en, req;
   logic [31:0]                    cfg_rdata, rdata_q;
   logic                           win_valid, rd_ready, ack_wr;
   logic [ID_W-1:0]                win_id;

   assign rd_ready = bus_rd_i && bus_addr_i == A_READY;
   assign ack_wr   = bus_wr_i && bus_addr_i == A_ACK;

   irqc_regs #(.NUM_SRC(NUM_SRC), .NUM_LOCAL(NUM_LOCAL), .ADDR_W(ADDR_W)) u_regs (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_i        (bus_wr_i),
      .addr_i      (bus_addr_i),
      .wdata_i     (bus_wdata_i),
      .sense_o     (sense),
      .prio_o      (prio),
      .en_o        (en),
      .cfg_rdata_o (cfg_rdata)
   );

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_line
      irqc_src u_src (
         .clk    (clk),
         .rst_n  (rst_n),
         .irq_i  (irq_src_i[i]),
         .mode_i (sense[i]),
         .en_i   (en[i]),
         .take_i (rd_ready && win_valid && win_id == ID_W'(i)),
         .ack_i  (ack_wr && bus_wdata_i == 32'(i)),
         .req_o  (req[i])
      );
   end

   irqc_arb #(.NUM_SRC(NUM_SRC), .ID_W(ID_W)) u_arb (
      .clk     (clk),
      .rst_n   (rst_n),
      .req_i   (req),
      .prio_i  (prio),
      .valid_o (win_valid),
      .id_o    (win_id)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rdata_q <= '0;
      else if (bus_rd_i)
         rdata_q <= rd_ready ? (win_valid ? {1'b1, 31'(win_id)} : IDLE_WORD) : cfg_rdata;
   end

   assign bus_rdata_o = rdata_q;
   assign cpu_irq_o   = win_valid;

   a_r8_valid_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_ready && cpu_irq_o) |=> bus_rdata_o[31]);
   a_r8_idle_word: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_ready && !cpu_irq_o) |=> bus_rdata_o == IDLE_WORD);
   a_r12_rdata_held: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd_i |=> $stable(bus_rdata_o));

endmodule

// File: tb/irq_prio_ctrl_bench.sv
module irq_prio_ctrl_bench;

   localparam int CLK_PERIOD = 10;
   localparam int N  = 32;
   localparam int NL = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [N-1:0]  irq_src = '0;
   logic          bus_wr = 1'b0, bus_rd = 1'b0;
   logic [11:0]   bus_addr = '0;
   logic [31:0]   bus_wdata = '0, bus_rdata;
   logic          cpu_irq;

   logic [N-1:0]  s_drv = '0;
   logic [1:0]    m_sense [N];
   logic [7:0]    m_prio  [N];
   bit            m_en [N], m_svc [N], m_lat [N], m_prev [N];
   int            n_chk = 0, n_fail = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   irq_prio_ctrl #(.NUM_SRC(N), .NUM_LOCAL(NL), .ADDR_W(12)) u_irq_prio_ctrl (
      .clk(clk), .rst_n(rst_n), .irq_src_i(irq_src), .bus_wr_i(bus_wr), .bus_rd_i(bus_rd),
      .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata), .cpu_irq_o(cpu_irq));

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   function automatic int s_addr(int i);
      int j = (i < NL) ? i : i - NL;
      return ((i < NL) ? 'h014 : 'h100) + (j / 16) * 4;
   endfunction
   function automatic int p_addr(int i);
      int j = (i < NL) ? i : i - NL;
      return ((i < NL) ? 'h020 : 'h200) + (j / 4) * 4;
   endfunction
   function automatic int s_bit(int i);
      return (((i < NL) ? i : i - NL) * 2) % 32;
   endfunction
   function automatic int p_bit(int i);
      return (((i < NL) ? i : i - NL) * 8) % 32;
   endfunction

   function automatic bit m_pend(int i);
      if (m_sense[i] >= 2) return m_lat[i];
      return irq_src[i] ^ (m_sense[i] == 2'd1);
   endfunction

   function automatic int m_winner();
      int w = -1;
      for (int i = 0; i < N; i++)
         if (m_pend(i) && m_en[i] && !m_svc[i] && (w < 0 || m_prio[i] > m_prio[w])) w = i;
      return w;
   endfunction

   function automatic logic [31:0] m_cfg(int a);
      logic [31:0] r = '0;
      for (int i = 0; i < N; i++) begin
         if (a == s_addr(i)) r = r | (32'(m_sense[i]) << s_bit(i));
         if (a == p_addr(i)) r = r | (32'(m_prio[i]) << p_bit(i));
      end
      return r;
   endfunction

   task automatic cyc(string tag, bit wr, bit rd, int a, logic [31:0] d);
      logic [31:0] exp_rd;
      int w;
      bit hit, edg;
      @(negedge clk);
      irq_src = s_drv; bus_wr = wr; bus_rd = rd; bus_addr = 12'(a); bus_wdata = d;
      #1;
      w = m_winner();
      exp_rd = (a == 'h06C) ? ((w >= 0) ? {1'b1, 31'(w)} : 32'h0) : m_cfg(a);
      @(posedge clk);
      #1;
      for (int i = 0; i < N; i++) begin
         hit = wr && a == 'h0B4 && d == 32'(i);
         edg = (m_sense[i] == 2 && irq_src[i] && !m_prev[i]) ||
               (m_sense[i] == 3 && !irq_src[i] && m_prev[i]);
         if (m_sense[i] < 2) m_lat[i] = 0;
         else if (edg)       m_lat[i] = 1;
         else if (hit)       m_lat[i] = 0;
         m_prev[i] = irq_src[i];
         if (rd && a == 'h06C && w == i) m_svc[i] = 1;
         else if (hit)                   m_svc[i] = 0;
         if (wr) begin
            if (a == 'h0A0 && d == 32'(i)) m_en[i] = 1;
            if (a == 'h0A4 && d == 32'(i)) m_en[i] = 0;
            if (a == s_addr(i)) m_sense[i] = d[s_bit(i) +: 2];
            if (a == p_addr(i)) m_prio[i] = d[p_bit(i) +: 8];
         end
      end
      bus_wr = 0; bus_rd = 0;
      @(negedge clk);
      if (rd) check({tag, " read"}, bus_rdata, exp_rd);
      check({tag, " R11 irq"}, {31'b0, cpu_irq}, {31'b0, m_winner() >= 0});
   endtask

   task automatic wr_reg(string tag, int a, logic [31:0] d); cyc(tag, 1, 0, a, d); endtask
   task automatic rd_reg(string tag, int a);                  cyc(tag, 0, 1, a, 0); endtask

   task automatic report();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
   end

   initial begin
      int k, op;
      void'($urandom(32'd20240611));
      for (int i = 0; i < N; i++) begin
         m_sense[i] = 0; m_prio[i] = 0; m_en[i] = 0; m_svc[i] = 0; m_lat[i] = 0; m_prev[i] = 0;
      end
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      check("R1 irq after reset", {31'b0, cpu_irq}, 32'h0);
      rd_reg("R1 ready idle R8", 'h06C);
      check("R1 idle word", bus_rdata, 32'h0);
      rd_reg("R1 sense word", 'h014);
      rd_reg("R1 prio word", 'h200);
      // R4 / R5: packing and readback
      wr_reg("R4", 'h100, 32'h0000_00E4);
      rd_reg("R4 shared sense", 'h100);
      check("R4 literal", bus_rdata, 32'h0000_00E4);
      wr_reg("R5", 'h204, 32'h1122_3344);
      rd_reg("R5 shared prio", 'h204);
      check("R5 literal", bus_rdata, 32'h1122_3344);
      wr_reg("R5", 'h204, 32'h0);
      // R6: out-of-range enable aliasing onto input 5 must not enable it
      s_drv[5] = 1'b1;
      wr_reg("R6 range", 'h0A0, 37);
      check("R6 no alias", {31'b0, cpu_irq}, 32'h0);
      wr_reg("R6 set", 'h0A0, 5);
      check("R6 enabled", {31'b0, cpu_irq}, 32'h1);
      wr_reg("R6 clr", 'h0A4, 5);
      check("R6 disabled", {31'b0, cpu_irq}, 32'h0);
      s_drv[5] = 1'b0;
      // R7: tie then magnitude; R12 immediate effect
      wr_reg("R7", 'h020, 32'h4000_0000);
      wr_reg("R7", 'h028, 32'h0000_4000);
      s_drv[3] = 1'b1; s_drv[9] = 1'b1;
      wr_reg("R7", 'h0A0, 3);
      wr_reg("R7", 'h0A0, 9);
      rd_reg("R7 tie", 'h06C);
      check("R7 tie lowest", bus_rdata, 32'h8000_0003);
      wr_reg("R10 ack", 'h0B4, 3);
      wr_reg("R12 prio", 'h028, 32'h0000_5000);
      rd_reg("R12 next cycle", 'h06C);
      check("R7 larger wins", bus_rdata, 32'h8000_0009);
      rd_reg("R9 other wins", 'h06C);
      check("R9 masked", bus_rdata, 32'h8000_0003);
      rd_reg("R9 all busy", 'h06C);
      check("R9 idle", bus_rdata, 32'h0);
      wr_reg("R10 bad ack", 'h0B4, 35);
      check("R10 range ignored", {31'b0, cpu_irq}, 32'h0);
      wr_reg("R10 ack", 'h0B4, 9);
      check("R10 level again", {31'b0, cpu_irq}, 32'h1);
      wr_reg("R10 ack", 'h0B4, 3);
      s_drv[3] = 1'b0; s_drv[9] = 1'b0;
      wr_reg("R2", 'h0A4, 3);
      wr_reg("R2", 'h0A4, 9);
      // R2: active-low level on input 17
      wr_reg("R2 low", 'h0A0, 17);
      check("R2 low level", {31'b0, cpu_irq}, 32'h1);
      rd_reg("R2 low read", 'h06C);
      wr_reg("R2", 'h0A4, 17);
      wr_reg("R2", 'h0B4, 17);
      // R3: rising on 18, falling on 19
      wr_reg("R3", 'h0A0, 18);
      s_drv[18] = 1'b1; cyc("R3 rise", 0, 0, 0, 0);
      s_drv[18] = 1'b0; cyc("R3 back", 0, 0, 0, 0);
      check("R3 latched", {31'b0, cpu_irq}, 32'h1);
      rd_reg("R3 rise read", 'h06C);
      check("R3 id", bus_rdata, 32'h8000_0012);
      wr_reg("R3 ack", 'h0B4, 18);
      check("R3 cleared", {31'b0, cpu_irq}, 32'h0);
      s_drv[19] = 1'b1;
      wr_reg("R3", 'h0A0, 19);
      s_drv[19] = 1'b0; cyc("R3 fall", 0, 0, 0, 0);
      rd_reg("R3 fall read", 'h06C);
      check("R3 fall id", bus_rdata, 32'h8000_0013);
      wr_reg("R3 ack", 'h0B4, 19);
      // random phase
      for (int n = 0; n < 3000; n++) begin
         s_drv = s_drv ^ ($urandom & $urandom & $urandom);
         op = $urandom_range(0, 99);
         if (op < 30) rd_reg("R8 rnd", 'h06C);
         else if (op < 42) begin
            k = $urandom_range(0, N - 1);
            for (int t = 0; t < N; t++)
               if (m_svc[(k + t) % N]) begin k = (k + t) % N; break; end
            wr_reg("R10 rnd", 'h0B4, ($urandom_range(0, 9) == 0) ? 32'(N + 3) : 32'(k));
         end else if (op < 50)
            wr_reg("R4 rnd", ($urandom_range(0, 1) == 0) ? 'h014 : 'h100, $urandom);
         else if (op < 60)
            wr_reg("R5 rnd", ($urandom_range(0, 1) == 0) ? 'h020 + 4 * $urandom_range(0, 3)
                                                       : 'h200 + 4 * $urandom_range(0, 3), $urandom);
         else if (op < 68)
            wr_reg("R6 rnd", ($urandom_range(0, 2) == 0) ? 'h0A4 : 'h0A0, $urandom_range(0, 39));
         else if (op < 74)
            rd_reg("R12 rnd", ($urandom_range(0, 1) == 0) ? 'h100 : 'h024);
         else
            cyc("R7 rnd", 0, 0, 0, 0);
      end
      report();
   end

endmodule